// File: doc/BRIEF.md
# Spin-Controlled Register Target

This block is a bus target on a simple parallel fetch/store bus. It claims a window of two adjacent addresses. The lower word is a control register. The upper word is a read-only status word that reports a simulated spinning device. Starting, stopping and querying the device are not separate bus commands. A master performs them as ordinary stores and fetches to the two addresses.

A master places an address on the bus, raises either the fetch or the store strobe, and waits for the acknowledge. Only the rising edge of a strobe opens a transfer, so a strobe that stays high is answered once. The target answers only addresses inside its window. Any other address gets no answer, and the master gives up after its own timeout. The error flag travels with the acknowledge. It marks accesses the target refuses: a store to the status word in the strict mode, or a request that raises both strobes together. After a start, the device needs a fixed number of cycles before it reports itself spun up.

Top module: `csr_spin_dev`

## Requirements
- R1: The target acknowledges only BASE_ADDR and BASE_ADDR+1. An access to any other address gets no acknowledge, and the master sees no response within 16 cycles.
- R2: `busAck` is a one-cycle pulse. It rises in the cycle after the first cycle in which a strobe is high. A strobe held high for several cycles produces exactly one acknowledge. A new transfer needs the strobe to be low for at least one cycle in between.
- R3: A store of any nonzero value to BASE_ADDR starts the device. Status bit 0 then reads 1.
- R4: A store of zero to BASE_ADDR stops the device. Status bits 0 and 1 both read 0.
- R5: A fetch from BASE_ADDR returns the last value stored there, all DATA_W bits.
- R6: The status word at BASE_ADDR+1 carries running in bit 0 and spin-up complete in bit 1, with all other bits 0. Bit 1 becomes 1 exactly SPINUP_CYCLES cycles after the acknowledge of the starting store. A nonzero store while the device is already running does not restart that count. A start after a stop begins a fresh count.
- R7: With REJECT_STATUS_STORE=1, a store to BASE_ADDR+1 is acknowledged with `busErr`=1 and changes no state.
- R8: With REJECT_STATUS_STORE=0, a store to BASE_ADDR+1 is acknowledged with `busErr`=0 and changes no state.
- R9: A request with fetch and store both high, to an owned address, is acknowledged with `busErr`=1 and changes no state.
- R10: After reset the control register holds 0, the status word reads 0, and `busAck`, `busErr` and `busRdata` are 0.
- R11: `busErr` is 1 only together with `busAck`. `busRdata` is 0 in every cycle without an acknowledge, and also on store, error and both-strobe acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Address lines |
| busWdata | input | DATA_W | Write data lines |
| busFetch | input | 1 | Fetch strobe |
| busStore | input | 1 | Store strobe |
| busRdata | output | DATA_W | Read data, valid during acknowledge |
| busAck | output | 1 | One-cycle response pulse |
| busErr | output | 1 | Response marks a refused access |

## Verification
A corrupted control register appears on the very next fetch of the lower address. A spin-up counter that is off by one cycle flips status bit 1 one fetch early or late. The bench times its fetches to land on both sides of the expected edge so that this error shows. A decode fault shows at once: either a spurious acknowledge on a hole, or a timeout on an owned address. A second instance in the permissive mode sits on the same bus at another base. It shows whether the status-store mode and the window compare stay separate per instance.

// File: rtl/csr_spin_pkg.sv
package csr_spin_pkg;

  // Per-transfer strobes from the decode/handshake control to the datapath
  typedef struct packed {
    logic respond;   // an acknowledge goes out next cycle
    logic fail;      // that acknowledge carries the error flag
    logic wrCtrl;    // accepted store to the control word
    logic rdCtrl;    // accepted fetch of the control word
    logic rdStatus;  // accepted fetch of the status word
  } csr_strb_t;

endpackage

// File: rtl/csr_spin_ctrl.sv
module csr_spin_ctrl
  import csr_spin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter bit REJECT_STATUS_STORE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busFetch,
  input  logic              busStore,
  output csr_strb_t         strb,
  output logic              busAck,
  output logic              busErr
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BASE_ADDR + 1'b1);

  logic hitCtrl, hitStat, anyStrobe, strobeSeen, newReq, bothStrobes;

  assign hitCtrl     = (busAddr == BASE_ADDR);
  assign hitStat     = (busAddr == STAT_ADDR);
  assign anyStrobe   = busFetch | busStore;
  assign bothStrobes = busFetch & busStore;
  assign newReq      = anyStrobe & ~strobeSeen & (hitCtrl | hitStat);

  always_comb begin
    strb          = '0;
    strb.respond  = newReq;
    strb.fail     = newReq & (bothStrobes |
                    (busStore & hitStat & REJECT_STATUS_STORE));
    strb.wrCtrl   = newReq & busStore & ~busFetch & hitCtrl;
    strb.rdCtrl   = newReq & busFetch & ~busStore & hitCtrl;
    strb.rdStatus = newReq & busFetch & ~busStore & hitStat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeSeen <= 1'b0;
      busAck     <= 1'b0;
      busErr     <= 1'b0;
    end else begin
      strobeSeen <= anyStrobe;
      busAck     <= strb.respond;
      busErr     <= strb.fail;
    end
  end

  // R2: the acknowledge never lasts longer than one cycle
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R2: an acknowledge is always preceded by a raised strobe
  assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busFetch || busStore));

  // R1: an acknowledge is only given for an address inside the window
  assert_no_ack_hole_R1: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> ($past(busAddr) == BASE_ADDR || $past(busAddr) == STAT_ADDR));

  // R11: the error flag rides only on an acknowledge
  assert_err_with_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busAck);

endmodule

// File: rtl/csr_spin_dp.sv
module csr_spin_dp
  import csr_spin_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SPINUP_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strb_t         strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  localparam int CNT_W = $clog2(SPINUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SPINUP_CYCLES - 1);

  logic [DATA_W-1:0] ctrlReg, statusWord, rdNext;
  logic [CNT_W-1:0]  spinCnt;
  logic              spinning, spunUp, storeZero;

  assign storeZero = (busWdata == '0);

  always_comb begin
    statusWord      = '0;
    statusWord[1:0] = {spunUp, spinning};
    if (strb.rdCtrl)        rdNext = ctrlReg;
    else if (strb.rdStatus) rdNext = statusWord;
    else                    rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      spinning <= 1'b0;
      spunUp   <= 1'b0;
      spinCnt  <= '0;
      busRdata <= '0;
    end else begin
      busRdata <= rdNext;
      if (strb.wrCtrl) ctrlReg <= busWdata;
      if (strb.wrCtrl && storeZero) begin
        spinning <= 1'b0;
        spunUp   <= 1'b0;
        spinCnt  <= '0;
      end else if (strb.wrCtrl && !spinning) begin
        spinning <= 1'b1;
        spunUp   <= 1'b0;
        spinCnt  <= '0;
      end else if (spinning && !spunUp) begin
        if (spinCnt == LAST_CNT) spunUp <= 1'b1;
        else                     spinCnt <= spinCnt + 1'b1;
      end
    end
  end

  // R6: spin-up complete only while running
  assert_spun_needs_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    spunUp |-> spinning);

  // R6: a start from standstill begins a fresh spin-up
  assert_start_fresh_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && !storeZero && !spinning) |=> (spinning && !spunUp));

  // R4: a zero store leaves the device stopped
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && storeZero) |=> (!spinning && !spunUp));

  // R7: without an accepted control store the control word holds
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> $stable(ctrlReg));

endmodule

// File: rtl/csr_spin_dev.sv
module csr_spin_dev
  import csr_spin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter int SPINUP_CYCLES = 20,
  parameter bit REJECT_STATUS_STORE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busFetch,
  input  logic              busStore,
  output logic [DATA_W-1:0] busRdata,
  output logic              busAck,
  output logic              busErr
);

  csr_strb_t strb;

  csr_spin_ctrl #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .REJECT_STATUS_STORE(REJECT_STATUS_STORE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busFetch(busFetch), .busStore(busStore),
    .strb(strb), .busAck(busAck), .busErr(busErr)
  );

  csr_spin_dp #(
    .DATA_W(DATA_W),
    .SPINUP_CYCLES(SPINUP_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  // R11: read data lines are quiet outside an acknowledge
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busAck |-> (busRdata == '0));

endmodule

// File: tb/sim_csr_spin_dev.sv
`timescale 1ns/1ps
module sim_csr_spin_dev;

  localparam int S = 20;
  localparam logic [15:0] B0 = 16'h0040;
  localparam logic [15:0] B1 = 16'h0080;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0, busWdata = '0;
  logic busFetch = 1'b0, busStore = 1'b0;
  logic [15:0] rd0, rd1;
  logic ack0, ack1, err0, err1;
  logic ack, err;
  logic [15:0] rdata;

  assign ack = ack0 | ack1;
  assign err = err0 | err1;
  assign rdata = rd0 | rd1;

  always #4 clk = ~clk;

  csr_spin_dev #(.BASE_ADDR(B0), .SPINUP_CYCLES(S), .REJECT_STATUS_STORE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busFetch(busFetch), .busStore(busStore),
    .busRdata(rd0), .busAck(ack0), .busErr(err0));

  csr_spin_dev #(.BASE_ADDR(B1), .SPINUP_CYCLES(S), .REJECT_STATUS_STORE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busFetch(busFetch), .busStore(busStore),
    .busRdata(rd1), .busAck(ack1), .busErr(err1));

  typedef struct {
    logic        err;
    logic [15:0] rdata;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit running = 1'b0;

  logic [15:0] mCtrl[2];
  bit          mRun[2];
  int          mStart[2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected response on every acknowledge
  always @(negedge clk) begin
    if (running) begin
      if (ack) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected acknowledge", 32'(ack), 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(err == e.err, {e.tag, " err"}, 32'(err), 32'(e.err));
          check(rdata == e.rdata, {e.tag, " rdata"}, 32'(rdata), 32'(e.rdata));
        end
      end else if (err || rdata != 16'h0) begin
        check(1'b0, "R11 idle lines", {15'd0, err, rdata}, 32'd0);
      end
    end
  end

  function automatic logic [15:0] mStatus(input int dev, input int edgeIdx);
    bit spun;
    spun = mRun[dev] && (edgeIdx - 1 >= mStart[dev] + S);
    return {14'd0, spun, mRun[dev]};
  endfunction

  // Driver: predicts the response, pushes it, runs one bus cycle
  task automatic busOp(input logic f, input logic s, input logic [15:0] a,
                       input logic [15:0] d, input string tag, input int holdExtra = 0);
    int dev;
    bit isStat;
    int waited;
    int edgeIdx;
    exp_t e;
    dev = -1;
    isStat = 1'b0;
    if (a == B0 || a == B0 + 16'd1) begin dev = 0; isStat = (a == B0 + 16'd1); end
    if (a == B1 || a == B1 + 16'd1) begin dev = 1; isStat = (a == B1 + 16'd1); end
    @(negedge clk);
    edgeIdx = cyc + 1;
    if (dev >= 0) begin
      e.tag = tag;
      e.err = (f && s) || (s && isStat && dev == 0);
      e.rdata = 16'h0;
      if (f && !s) e.rdata = isStat ? mStatus(dev, edgeIdx) : mCtrl[dev];
      if (s && !f && !isStat) begin
        mCtrl[dev] = d;
        if (d == 16'h0) mRun[dev] = 1'b0;
        else if (!mRun[dev]) begin mRun[dev] = 1'b1; mStart[dev] = edgeIdx; end
      end
      expQ.push_back(e);
    end
    busAddr = a; busWdata = d; busFetch = f; busStore = s;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!ack && waited < 16);
    if (dev >= 0) begin
      check(ack && waited == 1, {tag, " R2 ack timing"}, 32'(waited), 32'd1);
      for (int i = 0; i < holdExtra; i++) begin
        @(negedge clk);
        check(!ack, {tag, " R2 single ack on held strobe"}, 32'(ack), 32'd0);
      end
    end else begin
      check(!ack && waited == 16, {tag, " R1 hole timeout"}, 32'(waited), 32'd16);
    end
    busFetch = 1'b0; busStore = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mCtrl[i] = 16'h0; mRun[i] = 1'b0; mStart[i] = 0; end
    idle(3);
    // R10: quiet outputs while in reset
    check(!ack && !err && rdata == 16'h0, "R10 outputs in reset", {15'd0, err, rdata}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);
    check(!ack && !err && rdata == 16'h0, "R10 outputs after reset", {15'd0, err, rdata}, 32'd0);

    busOp(1, 0, B0, 16'h0, "R10 R5 control after reset");
    busOp(1, 0, B0 + 16'd1, 16'h0, "R10 R6 status after reset");

    // R1: holes around and far from both windows
    busOp(1, 0, B0 - 16'd1, 16'h0, "R1 fetch below window");
    busOp(0, 1, B0 + 16'd2, 16'h1234, "R1 store above window");
    busOp(1, 0, 16'h0000, 16'h0, "R1 fetch address zero");
    busOp(0, 1, 16'hFFFF, 16'hFFFF, "R1 store top address");

    // R3/R5: start and read back
    busOp(0, 1, B0, 16'hA5A5, "R3 start store");
    busOp(1, 0, B0, 16'h0, "R5 control readback");
    busOp(1, 0, B0 + 16'd1, 16'h0, "R3 status running");

    // R6: status fetched at staggered times across the spin-up edge
    for (int i = 0; i < 10; i++) begin
      idle(1);
      busOp(1, 0, B0 + 16'd1, 16'h0, "R6 spin-up timing");
    end

    // R6: nonzero store while running keeps the count
    busOp(0, 1, B0, 16'h0001, "R6 restore while running");
    busOp(1, 0, B0 + 16'd1, 16'h0, "R6 status after restore");
    busOp(1, 0, B0, 16'h0, "R5 control updated");

    // R7: strict mode refuses a status store
    busOp(0, 1, B0 + 16'd1, 16'hFFFF, "R7 status store refused");
    busOp(1, 0, B0 + 16'd1, 16'h0, "R7 status unchanged");
    busOp(1, 0, B0, 16'h0, "R7 control unchanged");

    // R9: both strobes at once
    busOp(1, 1, B0, 16'h0000, "R9 both strobes");
    busOp(1, 0, B0, 16'h0, "R9 control unchanged");
    busOp(1, 0, B0 + 16'd1, 16'h0, "R9 status unchanged");

    // R4: stop
    busOp(0, 1, B0, 16'h0000, "R4 stop store");
    busOp(1, 0, B0 + 16'd1, 16'h0, "R4 status stopped");
    busOp(1, 0, B0, 16'h0, "R5 control zero");

    // R6: restart begins a fresh count
    busOp(0, 1, B0, 16'h8000, "R6 restart");
    for (int i = 0; i < 8; i++) begin
      idle(2);
      busOp(1, 0, B0 + 16'd1, 16'h0, "R6 fresh spin-up");
    end

    // R8: permissive instance ignores status stores
    busOp(0, 1, B1 + 16'd1, 16'h00FF, "R8 status store ignored");
    busOp(1, 0, B1 + 16'd1, 16'h0, "R8 status still zero");
    busOp(0, 1, B1, 16'h0007, "R8 start second instance");
    busOp(0, 1, B1 + 16'd1, 16'h0000, "R8 status store while spinning");
    busOp(1, 0, B1, 16'h0, "R8 control unchanged");
    idle(S);
    busOp(1, 0, B1 + 16'd1, 16'h0, "R8 spin-up unaffected");

    // R2: held strobe answered once
    busOp(1, 0, B0, 16'h0, "R2 held fetch", 3);
    busOp(0, 1, B0, 16'h0, "R2 held store", 3);
    busOp(1, 0, B0 + 16'd1, 16'h0, "R4 stopped after held store");

    idle(3);
    check(expQ.size() == 0, "R2 all responses seen", 32'(expQ.size()), 32'd0);
    summary();
    $finish;
  end

endmodule